// File: doc/BRIEF.md
# Autopoll Device Address Selector

This block decides which bus device a host controller should interrogate next with a talk-register-0 command while no host request is waiting. It keeps its own record of the most recent command byte that went out on the bus and of the most recent talk-register-0 command among them. When asked to evaluate, it combines that history with a 16-bit enable mask and a service-request indication from the previous transaction, and produces either one poll command or nothing.

The chosen device stays the same from poll to poll. It changes only when the device currently being polled has left the mask, or when a service request arrived while the previous poll was the last command sent. In those cases the search moves to the next enabled address above the current one and wraps around to the lowest enabled address. A poll identical to the last transmitted command is withheld, because the bus transceiver keeps repeating such a command by itself while idle.

Top module: `autopoll_sel`

## Requirements
- R1: Bit 0 of `mask_i` is ignored. Address 0 is never polled, so a mask of 0x0001 produces no poll.
- R2: When no bit of `mask_i` other than bit 0 is set, an evaluation produces no poll.
- R3: The current address is the upper nibble of the recorded last poll command. After reset that record is 0x0C, i.e. address 0.
- R4: A strobe on `sent_valid_i` records `sent_cmd_i` as the last transmitted command. It also records the byte as the last poll command only when the byte's low nibble is 0xC (talk, register 0).
- R5: The current address is kept when its mask bit is set, unless a service request is flagged and the last transmitted command equals the last poll command.
- R6: When the address must change, the new address is the lowest set mask bit strictly above the current address. If no such bit exists, it is the lowest set mask bit overall.
- R7: The poll command is `{address, 4'hC}`: the address in bits 7:4 and 0xC in bits 3:0.
- R8: A poll whose command equals the last transmitted command is suppressed.
- R9: `poll_valid_o` is a one-cycle pulse in the cycle after the `eval_i` cycle that produced it. `poll_cmd_o` changes only together with that pulse, and it is 0x00 after reset.
- R10: An evaluation uses the history as it stood before a `sent_valid_i` strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Request to choose a poll in this cycle |
| mask_i | input | 16 | Enabled device addresses, bit n = address n |
| srq_i | input | 1 | Service request seen in the previous transaction |
| sent_valid_i | input | 1 | A command byte was transmitted on the bus |
| sent_cmd_i | input | 8 | The transmitted command byte |
| poll_valid_o | output | 1 | Poll command issued (one-cycle pulse) |
| poll_cmd_o | output | 8 | Poll command byte |

## Verification
The hard case is the advance on a service request. It needs three things in the right order: a talk-register-0 byte reported as sent, so that both history records agree, then `srq_i` together with `eval_i`, and a mask in which the current address has no higher neighbour, so that the search wraps. The directed stimulus builds this chain explicitly. The random phase feeds back the block's own poll commands as sent bytes about half the time, which drives the two records into agreement often enough to reach both the advance and the suppression paths.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;
  localparam logic [3:0] TALK_R0_NIB = 4'hC;

  function automatic logic is_talk_r0(input logic [3:0] low_nib);
    return low_nib == TALK_R0_NIB;
  endfunction
endpackage

// File: rtl/apsel_track.sv
module apsel_track
  import autopoll_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int CMD_W = ADDR_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sent_valid_i,
  input  logic [CMD_W-1:0] sent_cmd_i,
  output logic [CMD_W-1:0] last_cmd_o,
  output logic [CMD_W-1:0] last_poll_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_cmd_o  <= '0;
      last_poll_o <= {{ADDR_W{1'b0}}, TALK_R0_NIB};
    end else if (sent_valid_i) begin
      last_cmd_o <= sent_cmd_i;
      if (is_talk_r0(sent_cmd_i[3:0])) last_poll_o <= sent_cmd_i;
    end
  end
endmodule

// File: rtl/apsel_find.sv
module apsel_find #(
  parameter int ADDR_W = 4,
  localparam int NDEV = 1 << ADDR_W
) (
  input  logic [NDEV-1:0]   mask_i,
  input  logic [ADDR_W-1:0] cur_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [NDEV-1:0] above;

  for (genvar g = 0; g < NDEV; g++) begin : g_above
    assign above[g] = mask_i[g] && (g > int'(cur_i));
  end

  function automatic logic [ADDR_W-1:0] lowest(input logic [NDEV-1:0] v);
    logic [ADDR_W-1:0] idx;
    idx = '0;
    for (int i = NDEV - 1; i >= 0; i--) begin
      if (v[i]) idx = ADDR_W'(i);
    end
    return idx;
  endfunction

  always_comb begin
    if (|above) next_o = lowest(above);
    else        next_o = lowest(mask_i);
  end
endmodule

// File: rtl/autopoll_sel.sv
module autopoll_sel
  import autopoll_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int NDEV  = 1 << ADDR_W,
  localparam int CMD_W = ADDR_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eval_i,
  input  logic [NDEV-1:0]  mask_i,
  input  logic             srq_i,
  input  logic             sent_valid_i,
  input  logic [CMD_W-1:0] sent_cmd_i,
  output logic             poll_valid_o,
  output logic [CMD_W-1:0] poll_cmd_o
);
  logic [CMD_W-1:0]  last_cmd_q, last_poll_q;
  logic [NDEV-1:0]   masked;
  logic [ADDR_W-1:0] cur_addr, next_addr, sel_addr;
  logic [CMD_W-1:0]  cand_cmd;
  logic              must_move, fire;

  apsel_track #(.ADDR_W(ADDR_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sent_valid_i(sent_valid_i),
    .sent_cmd_i  (sent_cmd_i),
    .last_cmd_o  (last_cmd_q),
    .last_poll_o (last_poll_q)
  );

  // address 0 is reserved and never polled
  assign masked   = mask_i & ~NDEV'(1);
  assign cur_addr = last_poll_q[CMD_W-1:4];

  apsel_find #(.ADDR_W(ADDR_W)) u_find (
    .mask_i(masked),
    .cur_i (cur_addr),
    .next_o(next_addr)
  );

  assign must_move = (srq_i && (last_cmd_q == last_poll_q)) || !masked[cur_addr];
  assign sel_addr  = must_move ? next_addr : cur_addr;
  assign cand_cmd  = {sel_addr, TALK_R0_NIB};
  // transceiver already repeats an identical command while idle
  assign fire      = eval_i && (|masked) && (cand_cmd != last_cmd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_valid_o <= 1'b0;
      poll_cmd_o   <= '0;
    end else begin
      poll_valid_o <= fire;
      if (fire) poll_cmd_o <= cand_cmd;
    end
  end
endmodule

// File: rtl/autopoll_sel_chk.sv
module autopoll_sel_chk #(
  parameter int ADDR_W = 4,
  localparam int NDEV  = 1 << ADDR_W,
  localparam int CMD_W = ADDR_W + 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             eval_i,
  input logic [NDEV-1:0]  mask_i,
  input logic             poll_valid_o,
  input logic [CMD_W-1:0] poll_cmd_o,
  input logic [CMD_W-1:0] last_cmd_q
);
  logic [NDEV-1:0] mask_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_d <= '0;
    else         mask_d <= mask_i;
  end

  a_r9_follows_eval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_valid_o |-> $past(eval_i));
  a_r9_cmd_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poll_valid_o |-> $stable(poll_cmd_o));
  a_r7_talk_r0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_valid_o |-> poll_cmd_o[3:0] == 4'hC);
  a_r1_no_addr0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_valid_o |-> poll_cmd_o[CMD_W-1:4] != '0);
  a_r2_in_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_valid_o |-> mask_d[poll_cmd_o[CMD_W-1:4]]);
  a_r8_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_valid_o |-> poll_cmd_o != $past(last_cmd_q));
endmodule

bind autopoll_sel autopoll_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .eval_i      (eval_i),
  .mask_i      (mask_i),
  .poll_valid_o(poll_valid_o),
  .poll_cmd_o  (poll_cmd_o),
  .last_cmd_q  (last_cmd_q)
);

// File: tb/autopoll_sel_tb.sv
module autopoll_sel_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        eval_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic        srq_i = 1'b0;
  logic        sent_valid_i = 1'b0;
  logic [7:0]  sent_cmd_i = '0;
  logic        poll_valid_o;
  logic [7:0]  poll_cmd_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  int m_last_cmd, m_last_poll;
  bit exp_v;
  int exp_c;
  string pend_tag;

  always #10 clk_i = ~clk_i;

  autopoll_sel u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .eval_i(eval_i), .mask_i(mask_i),
    .srq_i(srq_i), .sent_valid_i(sent_valid_i), .sent_cmd_i(sent_cmd_i),
    .poll_valid_o(poll_valid_o), .poll_cmd_o(poll_cmd_o)
  );

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // compare outputs produced by the previous step, then drive and predict
  task automatic step(bit ev, int mask, bit srq, bit sv, int sc, string tag);
    int en, addr, pick;
    bit move;
    @(negedge clk_i);
    check({pend_tag, " valid"}, int'(poll_valid_o), int'(exp_v));
    check({pend_tag, " cmd"}, int'(poll_cmd_o), exp_c);
    eval_i = ev; mask_i = mask[15:0]; srq_i = srq;
    sent_valid_i = sv; sent_cmd_i = sc[7:0];
    pend_tag = tag;
    exp_v = 0;
    en = mask & 'hFFFE;
    if (ev && en != 0) begin
      addr = m_last_poll / 16;
      move = (srq && m_last_cmd == m_last_poll) || ((en >> addr) & 1) == 0;
      if (move) begin
        pick = -1;
        for (int k = addr + 1; k < 16; k++) if (pick < 0 && ((en >> k) & 1)) pick = k;
        for (int k = 1; k < 16; k++) if (pick < 0 && ((en >> k) & 1)) pick = k;
        addr = pick;
      end
      if (addr * 16 + 12 != m_last_cmd) begin
        exp_v = 1;
        exp_c = addr * 16 + 12;
      end
    end
    if (sv) begin
      m_last_cmd = sc & 'hFF;
      if ((sc & 'hF) == 'hC) m_last_poll = sc & 'hFF;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_last_cmd = 0; m_last_poll = 'h0C; exp_v = 0; exp_c = 0; pend_tag = "R9 reset";
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R9 reset valid", int'(poll_valid_o), 0);
    check("R9 reset cmd", int'(poll_cmd_o), 0);
    rst_ni = 1'b1;

    step(1, 'h0000, 0, 0, 0,     "R2 empty mask");
    step(1, 'h0001, 0, 0, 0,     "R1 only addr0");
    step(1, 'h0004, 0, 0, 0,     "R3 reset addr0 absent -> 0x2C");
    step(0, 'h0004, 0, 1, 'h2C,  "R4 record poll sent");
    step(1, 'h0004, 0, 0, 0,     "R8 repeat suppressed");
    step(0, 'h0014, 0, 1, 'h3F,  "R4 non-poll byte");
    step(1, 'h0014, 0, 0, 0,     "R5 keep present addr");
    step(1, 'h0014, 1, 0, 0,     "R5 srq but last cmd differs");
    step(0, 'h0014, 0, 1, 'h2C,  "R4 poll sent again");
    step(1, 'h0014, 1, 0, 0,     "R6 srq advance to 0x4C");
    step(0, 'h0014, 0, 1, 'h4C,  "R4 record 0x4C");
    step(1, 'h0014, 1, 0, 0,     "R6 srq wrap to 0x2C");
    step(1, 'h0014, 0, 1, 'h2C,  "R10 eval with same-cycle sent");
    step(1, 'hA00B, 0, 0, 0,     "R6 addr absent jump above");
    step(0, 'hA00B, 0, 0, 0,     "R9 no eval holds cmd");
    step(0, 'h0000, 0, 1, 'hFC,  "R4 record 0xFC");
    step(1, 'h8003, 1, 0, 0,     "R6 wrap from top to lowest");
    step(1, 'h0001, 1, 0, 0,     "R1 addr0 with srq");

    for (int i = 0; i < 3000; i++) begin
      int msk, sc;
      bit sv;
      case ($urandom_range(0, 3))
        0: msk = 1 << $urandom_range(0, 15);
        1: msk = (1 << $urandom_range(0, 15)) | (1 << $urandom_range(0, 15));
        2: msk = 0;
        default: msk = int'($urandom_range(0, 65535));
      endcase
      sv = $urandom_range(0, 1);
      if ($urandom_range(0, 1)) sc = exp_c;
      else if ($urandom_range(0, 1)) sc = $urandom_range(0, 15) * 16 + 12;
      else sc = $urandom_range(0, 255);
      step($urandom_range(0, 3) != 0, msk, $urandom_range(0, 1), sv, sc, "R7 random");
    end
    step(0, 0, 0, 0, 0, "R9 flush");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule